// File: doc/BRIEF.md
# Load/Store Address Sequencer

This block carries out the data-movement part of a 16-bit, word-addressed instruction set. When an instruction is offered with `start` while the block is idle, it decodes the opcode and forms an effective address. It then steps through the memory accesses that the addressing mode needs, one per cycle, on a synchronous single-port memory. Supported forms are the PC-relative load and store, the base-plus-offset load and store, the indirect load and store, and the address-only computation (load effective address). Any other opcode is left to the rest of the core.

Operand values come from the surrounding core in the cycle that `start` is high. These are the incremented PC, the base register value and the store source value. A load or an address computation ends with a one-cycle destination register write and an update of the three condition flags. A store ends with a one-cycle memory write. Every accepted instruction raises `done` in exactly one cycle, its last one. Instruction fetch, the ALU and the register file live outside.

Top module: `ldst_agu`

## Requirements
- R1: The opcode is `instr[15:12]` and the register index is `instr[11:9]`. Accepted opcodes are 0010 (PC-relative load), 1010 (indirect load), 1110 (address only), 0011 (PC-relative store), 1011 (indirect store), 0110 (base load) and 0111 (base store). With any other opcode, `start` is ignored: the block stays idle, makes no memory access, no register write and no `done`, and leaves the flags unchanged.
- R2: The PC-relative address is `pc_next` plus `instr[8:0]` sign-extended to 16 bits, taken modulo 2^16.
- R3: The base-plus-offset address is `base_val` plus `instr[5:0]` sign-extended, taken modulo 2^16.
- R4: A direct load reads memory in the first cycle after acceptance (`mem_re`=1). In the second cycle it drives `reg_we`=1, `reg_wdata`=`mem_rdata` and `done`=1. Memory read data appears one cycle after the read.
- R5: A direct store drives `mem_we`=1, `mem_addr` and `mem_wdata`=`src_val` in the first cycle after acceptance, with `done`=1 and `reg_we`=0.
- R6: An indirect access reads a pointer at the PC-relative address in the first cycle. The second cycle makes no memory access. The third cycle accesses memory at the pointer value. An indirect load writes the register with `done` in the fourth cycle. An indirect store writes memory with `done` in the third cycle.
- R7: The address-only instruction drives `reg_we`=1 with `reg_wdata` equal to the PC-relative address and `done`=1 in the first cycle after acceptance, with no memory access.
- R8: `flags` is {N,Z,P}. After each register write it holds exactly one set bit: N if bit 15 of the written value is 1, Z if the value is 0, and P otherwise. Without a register write the flags hold their value, so stores leave them unchanged.
- R9: `busy` is 1 from the cycle after acceptance through the `done` cycle. A `start`, instruction or operand change while busy has no effect on the running access.
- R10: `mem_re` and `mem_we` are never high together. `done` lasts one cycle per accepted instruction.
- R11: After reset the block is idle: `busy`, `done`, `mem_re`, `mem_we` and `reg_we` are 0, and `flags` is 3'b010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Instruction offered this cycle |
| instr | input | 16 | Instruction word |
| pc_next | input | 16 | Incremented PC of the instruction |
| base_val | input | 16 | Value of the base register named in instr[8:6] |
| src_val | input | 16 | Value of the store source register named in instr[11:9] |
| busy | output | 1 | Access sequence in progress |
| done | output | 1 | Last cycle of the sequence |
| mem_addr | output | 16 | Memory word address |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the read |
| reg_we | output | 1 | Destination register write enable |
| reg_idx | output | 3 | Destination register index |
| reg_wdata | output | 16 | Destination register write value |
| flags | output | 3 | Condition flags {N,Z,P} |

## Verification
The assertions take for granted that the memory answers every read exactly one cycle later and that `mem_rdata` holds that word through the capture cycle. They also assume the operand inputs are valid in the cycle `start` is sampled while idle. The bench memory is an associative model that registers read data on the edge after each `mem_re`, and it keeps every word written by a store so that later loads return it. All inputs change on falling edges. Some sequences keep `start` high with a different instruction and altered operands while busy, to show that a running access is not disturbed.

// File: rtl/ldst_pkg.sv
// Shared constants and types for the load/store address sequencer.
// Assumes a 4-bit opcode at the top of the instruction word.
package ldst_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OP_LD_PC  = 4'b0010;
    localparam logic [OPC_W-1:0] OP_LD_IND = 4'b1010;
    localparam logic [OPC_W-1:0] OP_ADDR   = 4'b1110;
    localparam logic [OPC_W-1:0] OP_ST_PC  = 4'b0011;
    localparam logic [OPC_W-1:0] OP_ST_IND = 4'b1011;
    localparam logic [OPC_W-1:0] OP_LD_BASE = 4'b0110;
    localparam logic [OPC_W-1:0] OP_ST_BASE = 4'b0111;

    // Flag vector order is {N, Z, P}
    localparam int FLAG_W = 3;
    localparam logic [FLAG_W-1:0] FLAG_RESET = 3'b010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_REQ,
        S_PTR_CAP,
        S_DAT_RD,
        S_DAT_CAP,
        S_DAT_WR,
        S_ADDR_WB
    } seq_state_e;

endpackage

// File: rtl/ldst_decode.sv
// Opcode classifier: tells whether an opcode belongs to this block and,
// if so, which access kind and addressing mode it uses.
// Assumes: purely combinational, no state.
module ldst_decode
    import ldst_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output logic             valid,
    output logic             is_store,
    output logic             is_addr,
    output logic             indirect,
    output logic             base_mode
);

    // Map each opcode to its access attributes
    always_comb begin
        valid     = 1'b0;
        is_store  = 1'b0;
        is_addr   = 1'b0;
        indirect  = 1'b0;
        base_mode = 1'b0;
        case (opc)
            OP_LD_PC:   valid = 1'b1;
            OP_LD_IND:  begin valid = 1'b1; indirect = 1'b1; end
            OP_ADDR:    begin valid = 1'b1; is_addr = 1'b1; end
            OP_ST_PC:   begin valid = 1'b1; is_store = 1'b1; end
            OP_ST_IND:  begin valid = 1'b1; is_store = 1'b1; indirect = 1'b1; end
            OP_LD_BASE: begin valid = 1'b1; base_mode = 1'b1; end
            OP_ST_BASE: begin valid = 1'b1; is_store = 1'b1; base_mode = 1'b1; end
            default:    valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/ldst_agen.sv
// Effective-address adder: sign-extends the offset field and adds it
// to either the incremented PC or the base register value.
// Assumes the short offset occupies the low bits of the long one.
module ldst_agen #(
    parameter int XLEN    = 16,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic               base_mode,
    input  logic [PCOFF_W-1:0] off_field,
    input  logic [XLEN-1:0]    pc_next,
    input  logic [XLEN-1:0]    base_val,
    output logic [XLEN-1:0]    ea
);

    localparam int PC_PAD = XLEN - PCOFF_W;
    localparam int B_PAD  = XLEN - BOFF_W;

    logic [XLEN-1:0] pc_off_x;
    logic [XLEN-1:0] base_off_x;

    // Sign-extend both offset widths
    always_comb begin
        pc_off_x   = {{PC_PAD{off_field[PCOFF_W-1]}}, off_field};
        base_off_x = {{B_PAD{off_field[BOFF_W-1]}}, off_field[BOFF_W-1:0]};
    end

    // Select the anchor and add the offset
    always_comb begin
        if (base_mode) ea = base_val + base_off_x;
        else           ea = pc_next + pc_off_x;
    end

endmodule

// File: rtl/ldst_seq.sv
// Access sequencer: accepts a decoded instruction while idle, holds its
// address, source data and register index, and steps through pointer
// read, data read/write or register write-back, one state per cycle.
// Assumes memory read data is valid one cycle after the read request
// and that the data and address widths are equal (pointer becomes address).
module ldst_seq
    import ldst_pkg::*;
#(
    parameter int XLEN   = 16,
    parameter int RIDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dec_valid,
    input  logic              dec_store,
    input  logic              dec_addr,
    input  logic              dec_indirect,
    input  logic [XLEN-1:0]   ea,
    input  logic [XLEN-1:0]   src_val,
    input  logic [RIDX_W-1:0] idx_field,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [XLEN-1:0]   reg_wdata
);

    seq_state_e        state;
    logic [XLEN-1:0]   addr_q;
    logic [XLEN-1:0]   src_q;
    logic [RIDX_W-1:0] idx_q;
    logic              store_q;
    logic              accept;

    // Accept only in idle and only for opcodes this block owns
    always_comb accept = (state == S_IDLE) && start && dec_valid;

    // State register and held operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            addr_q  <= '0;
            src_q   <= '0;
            idx_q   <= '0;
            store_q <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        addr_q  <= ea;
                        src_q   <= src_val;
                        idx_q   <= idx_field;
                        store_q <= dec_store;
                        if (dec_addr)          state <= S_ADDR_WB;
                        else if (dec_indirect) state <= S_PTR_REQ;
                        else if (dec_store)    state <= S_DAT_WR;
                        else                   state <= S_DAT_RD;
                    end
                end
                S_PTR_REQ: state <= S_PTR_CAP;
                S_PTR_CAP: begin
                    addr_q <= mem_rdata;
                    state  <= store_q ? S_DAT_WR : S_DAT_RD;
                end
                S_DAT_RD:  state <= S_DAT_CAP;
                default:   state <= S_IDLE;
            endcase
        end
    end

    // Memory-side strobes from the current state
    always_comb begin
        mem_re    = (state == S_PTR_REQ) || (state == S_DAT_RD);
        mem_we    = (state == S_DAT_WR);
        mem_addr  = addr_q;
        mem_wdata = src_q;
    end

    // Register-side write-back and completion
    always_comb begin
        reg_we    = (state == S_DAT_CAP) || (state == S_ADDR_WB);
        reg_wdata = (state == S_DAT_CAP) ? mem_rdata : addr_q;
        reg_idx   = idx_q;
        done      = (state == S_DAT_CAP) || (state == S_DAT_WR) || (state == S_ADDR_WB);
        busy      = (state != S_IDLE);
    end

    AST_NO_DUAL_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we)); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy); // R9
    AST_LOAD_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DAT_RD) |=> (reg_we && done)); // R4
    AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !reg_we); // R5
    AST_PTR_FOLLOWUP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR_CAP) |=> (mem_re || mem_we)); // R6
    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR_REQ) |=> (!mem_re && !mem_we && !done)); // R6

endmodule

// File: rtl/ldst_flags.sv
// Condition flag register {N,Z,P}: loaded from each register write-back
// value, held otherwise.
// Assumes write-back lasts one cycle per instruction.
module ldst_flags
    import ldst_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [XLEN-1:0]   wr_val,
    output logic [FLAG_W-1:0] flags
);

    logic neg;
    logic zero;

    // Classify the written value
    always_comb begin
        neg  = wr_val[XLEN-1];
        zero = (wr_val == '0);
    end

    // Flag register update
    always_ff @(posedge clk) begin
        if (!rst_n)     flags <= FLAG_RESET;
        else if (wr_en) flags <= {neg, zero, !neg && !zero};
    end

    AST_FLAG_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1); // R8
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(flags)); // R8

endmodule

// File: rtl/ldst_agu.sv
// Top of the load/store address sequencer: decodes the offered
// instruction, forms its effective address and runs the access sequence.
// Assumes operands are valid in the cycle start is sampled while idle.
module ldst_agu
    import ldst_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int RIDX_W  = 3,
    parameter int PCOFF_W = 9,
    parameter int BOFF_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [XLEN-1:0]   instr,
    input  logic [XLEN-1:0]   pc_next,
    input  logic [XLEN-1:0]   base_val,
    input  logic [XLEN-1:0]   src_val,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [XLEN-1:0]   mem_wdata,
    input  logic [XLEN-1:0]   mem_rdata,
    output logic              reg_we,
    output logic [RIDX_W-1:0] reg_idx,
    output logic [XLEN-1:0]   reg_wdata,
    output logic [FLAG_W-1:0] flags
);

    localparam int OPC_LSB  = XLEN - OPC_W;
    localparam int RIDX_LSB = OPC_LSB - RIDX_W;

    logic            dec_valid;
    logic            dec_store;
    logic            dec_addr;
    logic            dec_indirect;
    logic            dec_base;
    logic [XLEN-1:0] ea;

    ldst_decode u_decode (
        .opc       (instr[XLEN-1:OPC_LSB]),
        .valid     (dec_valid),
        .is_store  (dec_store),
        .is_addr   (dec_addr),
        .indirect  (dec_indirect),
        .base_mode (dec_base)
    );

    ldst_agen #(
        .XLEN    (XLEN),
        .PCOFF_W (PCOFF_W),
        .BOFF_W  (BOFF_W)
    ) u_agen (
        .base_mode (dec_base),
        .off_field (instr[PCOFF_W-1:0]),
        .pc_next   (pc_next),
        .base_val  (base_val),
        .ea        (ea)
    );

    ldst_seq #(
        .XLEN   (XLEN),
        .RIDX_W (RIDX_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dec_valid    (dec_valid),
        .dec_store    (dec_store),
        .dec_addr     (dec_addr),
        .dec_indirect (dec_indirect),
        .ea           (ea),
        .src_val      (src_val),
        .idx_field    (instr[OPC_LSB-1:RIDX_LSB]),
        .mem_rdata    (mem_rdata),
        .busy         (busy),
        .done         (done),
        .mem_addr     (mem_addr),
        .mem_re       (mem_re),
        .mem_we       (mem_we),
        .mem_wdata    (mem_wdata),
        .reg_we       (reg_we),
        .reg_idx      (reg_idx),
        .reg_wdata    (reg_wdata)
    );

    ldst_flags #(
        .XLEN (XLEN)
    ) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .wr_val (reg_wdata),
        .flags  (flags)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_re && !mem_we && !reg_we && !done)); // R11
    AST_REJECT_FOREIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !dec_valid) |=> !busy); // R1

endmodule

// File: tb/sim_ldst_agu.sv
module sim_ldst_agu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] pc_next = '0;
    logic [15:0] base_val = '0;
    logic [15:0] src_val = '0;
    logic        busy, done, mem_re, mem_we, reg_we;
    logic [15:0] mem_addr, mem_wdata, reg_wdata;
    logic [15:0] mem_rdata = '0;
    logic [2:0]  reg_idx;
    logic [2:0]  flags;

    int checks = 0;
    int failures = 0;
    logic [2:0] exp_flags = 3'b010;
    logic [15:0] bmem [logic [15:0]];

    typedef struct {
        bit          re;
        bit          we;
        logic [15:0] addr;
        logic [15:0] wdata;
        bit          rwe;
        logic [15:0] rval;
        bit          dn;
    } exp_t;

    always #2 clk = ~clk;

    ldst_agu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .pc_next(pc_next), .base_val(base_val), .src_val(src_val),
        .busy(busy), .done(done), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .flags(flags)
    );

    function automatic logic [15:0] rd(input logic [15:0] a);
        if (bmem.exists(a)) return bmem[a];
        return a ^ 16'h5A3C;
    endfunction

    // Bench memory: one-cycle read latency, writes kept for later reads
    always @(posedge clk) begin
        if (mem_re) mem_rdata <= rd(mem_addr);
        if (mem_we) bmem[mem_addr] = mem_wdata;
    end

    function automatic exp_t mk(input bit re, input bit we, input logic [15:0] addr,
                                input logic [15:0] wdata, input bit rwe,
                                input logic [15:0] rval, input bit dn);
        exp_t r;
        r.re = re; r.we = we; r.addr = addr; r.wdata = wdata;
        r.rwe = rwe; r.rval = rval; r.dn = dn;
        return r;
    endfunction

    function automatic logic [2:0] flag_of(input logic [15:0] v);
        if (v[15]) return 3'b100;
        if (v == 16'h0000) return 3'b010;
        return 3'b001;
    endfunction

    task automatic chkv(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic idle_check(input string tag);
        chkv(tag, "busy idle", busy, 0);
        chkv(tag, "done idle", done, 0);
        chkv(tag, "mem_re idle", mem_re, 0);
        chkv(tag, "mem_we idle", mem_we, 0);
        chkv(tag, "reg_we idle", reg_we, 0);
        chkv("R8", "flags", flags, exp_flags);
    endtask

    // Predict the cycle sequence of one instruction and compare every cycle
    task automatic run_op(input string tag, input logic [15:0] ins, input logic [15:0] pc,
                          input logic [15:0] base, input logic [15:0] src, input bit noisy);
        exp_t q[$];
        logic [15:0] ea_pc, ea_b, p;
        ea_pc = pc + {{7{ins[8]}}, ins[8:0]};
        ea_b  = base + {{10{ins[5]}}, ins[5:0]};
        case (ins[15:12])
            4'b0010: begin
                q.push_back(mk(1, 0, ea_pc, 0, 0, 0, 0));
                q.push_back(mk(0, 0, 0, 0, 1, rd(ea_pc), 1));
            end
            4'b0110: begin
                q.push_back(mk(1, 0, ea_b, 0, 0, 0, 0));
                q.push_back(mk(0, 0, 0, 0, 1, rd(ea_b), 1));
            end
            4'b1010: begin
                p = rd(ea_pc);
                q.push_back(mk(1, 0, ea_pc, 0, 0, 0, 0));
                q.push_back(mk(0, 0, 0, 0, 0, 0, 0));
                q.push_back(mk(1, 0, p, 0, 0, 0, 0));
                q.push_back(mk(0, 0, 0, 0, 1, rd(p), 1));
            end
            4'b0011: q.push_back(mk(0, 1, ea_pc, src, 0, 0, 1));
            4'b0111: q.push_back(mk(0, 1, ea_b, src, 0, 0, 1));
            4'b1011: begin
                p = rd(ea_pc);
                q.push_back(mk(1, 0, ea_pc, 0, 0, 0, 0));
                q.push_back(mk(0, 0, 0, 0, 0, 0, 0));
                q.push_back(mk(0, 1, p, src, 0, 0, 1));
            end
            4'b1110: q.push_back(mk(0, 0, 0, 0, 1, ea_pc, 1));
            default: ;
        endcase
        @(negedge clk);
        start = 1'b1; instr = ins; pc_next = pc; base_val = base; src_val = src;
        foreach (q[i]) begin
            @(negedge clk);
            if (noisy) begin
                start = 1'b1; instr = 16'hE1FF; pc_next = ~pc; base_val = ~base; src_val = ~src;
            end else begin
                start = 1'b0;
            end
            chkv(tag, "mem_re", mem_re, q[i].re);
            chkv(tag, "mem_we", mem_we, q[i].we);
            chkv(tag, "reg_we", reg_we, q[i].rwe);
            chkv(tag, "done", done, q[i].dn);
            chkv("R9", "busy", busy, 1);
            chkv("R10", "re and we together", mem_re && mem_we, 0);
            if (q[i].re || q[i].we) chkv(tag, "mem_addr", mem_addr, q[i].addr);
            if (q[i].we) chkv(tag, "mem_wdata", mem_wdata, q[i].wdata);
            if (q[i].rwe) begin
                chkv(tag, "reg_wdata", reg_wdata, q[i].rval);
                chkv("R1", "reg_idx", reg_idx, ins[11:9]);
                exp_flags = flag_of(q[i].rval);
            end
        end
        @(negedge clk);
        start = 1'b0;
        idle_check("R10");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chkv("R11", "reset busy", busy, 0);
        chkv("R11", "reset done", done, 0);
        chkv("R11", "reset mem_re", mem_re, 0);
        chkv("R11", "reset mem_we", mem_we, 0);
        chkv("R11", "reset reg_we", reg_we, 0);
        chkv("R11", "reset flags", flags, 3'b010);

        run_op("R2 R4", {4'b0010, 3'd1, 9'h004}, 16'h3001, 16'h0, 16'h0, 0);
        run_op("R2 R4", {4'b0010, 3'd2, 9'h1FC}, 16'h300D, 16'h0, 16'h0, 0);
        run_op("R5", {4'b0011, 3'd2, 9'h003}, 16'h3007, 16'h0, 16'h8001, 0);
        run_op("R4 R8", {4'b0010, 3'd3, 9'h00A}, 16'h3000, 16'h0, 16'h0, 0);
        run_op("R3 R4", {4'b0110, 3'd3, 3'd6, 6'h3E}, 16'h0, 16'h4000, 16'h0, 0);
        run_op("R3 R5", {4'b0111, 3'd4, 3'd5, 6'h1F}, 16'h0, 16'h1000, 16'h0000, 0);
        run_op("R3 R8", {4'b0110, 3'd0, 3'd5, 6'h1F}, 16'h0, 16'h1000, 16'h0, 0);
        run_op("R6", {4'b1010, 3'd5, 9'h010}, 16'h2000, 16'h0, 16'h0, 0);
        run_op("R6", {4'b1011, 3'd6, 9'h1FF}, 16'h0100, 16'h0, 16'h1234, 0);
        run_op("R6", {4'b1010, 3'd4, 9'h1FF}, 16'h0100, 16'h0, 16'h0, 0);
        run_op("R7 R2", {4'b1110, 3'd7, 9'h100}, 16'h0050, 16'h0, 16'h0, 0);
        run_op("R7 R8", {4'b1110, 3'd1, 9'h000}, 16'h0000, 16'h0, 16'h0, 0);
        run_op("R7 R2", {4'b1110, 3'd2, 9'h0FF}, 16'hFFF0, 16'h0, 16'h0, 0);
        run_op("R9 R4", {4'b0010, 3'd3, 9'h020}, 16'h0400, 16'h0, 16'h0, 1);
        run_op("R9 R6", {4'b1011, 3'd5, 9'h005}, 16'h0500, 16'h0, 16'h7777, 1);
        run_op("R9 R3", {4'b0111, 3'd1, 3'd2, 6'h20}, 16'h0, 16'h0800, 16'hFFFF, 1);
        run_op("R9 R6", {4'b1010, 3'd6, 9'h005}, 16'h0500, 16'h0, 16'h0, 1);
        run_op("R1", {4'b0001, 3'd1, 9'h1FF}, 16'h1111, 16'h2222, 16'h3333, 0);
        run_op("R1", {4'b0000, 3'd7, 9'h0FF}, 16'h1111, 16'h2222, 16'h3333, 0);
        run_op("R1", {4'b1111, 3'd0, 9'h025}, 16'h1111, 16'h2222, 16'h3333, 1);
        run_op("R1", {4'b1100, 3'd0, 9'h1C0}, 16'h1111, 16'h2222, 16'h3333, 0);
        run_op("R4", {4'b0010, 3'd0, 9'h0FF}, 16'h0801, 16'h0, 16'h0, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule